// File: doc/BRIEF.md
# Page-boundary write splitter

This block turns one write request, given as a start byte address and a byte count, into a series of page-program sub-requests. No sub-request runs past the end of a 256-byte page. A flash command sequencer sits downstream of it. Each sub-request carries three fields: the target address, the number of bytes, and the offset of those bytes within the caller's source buffer. The sequencer can then fetch the data and program one page at a time.

When the start address is not page-aligned, the first sub-request is cut down to the space left in the current page. Every sub-request after it starts on a page boundary. It is a full page, except the last one, which holds whatever bytes are left.

Sub-requests leave the block on a valid/ready handshake. After a sub-request is accepted, the block waits for a chunk-done pulse, which means the page program has finished, before it issues the next one. A single done pulse closes the whole request. A request with a byte count of zero produces no sub-requests and finishes at once.

Top module: `page_write_splitter`

## Requirements
- R1: After synchronous reset, `chunk_valid` and `done` are 0 and `req_ready` is 1.
- R2: Every sub-request stays inside one page: (`chunk_addr` mod 256) + `chunk_len` is at most 256.
- R3: For a page-aligned start address, the sub-requests are 256 bytes long, except the last one, which carries the remaining `req_len` mod 256 bytes.
- R4: For an unaligned start address A with count N, the first sub-request has length min(256 − (A mod 256), N) and address A.
- R5: Every sub-request after the first starts on a page boundary (`chunk_addr` mod 256 = 0).
- R6: No sub-request of length zero is issued. When N is a multiple of 256 and the start is aligned, exactly N/256 sub-requests are issued and nothing follows them.
- R7: The first sub-request has `chunk_off` 0. Both the address and the offset of each later sub-request equal those of the previous one plus its length.
- R8: A request accepted with `req_len` = 0 raises `done` for one cycle, in the cycle after acceptance, with no sub-request.
- R9: While `chunk_valid` is high and `chunk_ready` is low, the sub-request fields are held stable. After a sub-request is accepted, `chunk_valid` stays low until `chunk_done` is seen.
- R10: `req_ready` is high only when the block is idle. A request presented while the block is busy is ignored. `done` pulses in the cycle after the `chunk_done` of the last sub-request, and the block is idle while `done` is high.
- R11: Addresses are 24 bits wide and wrap from 0xFFFFFF to 0x000000 as a request advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | 24 | Start byte address |
| req_len | input | 16 | Total byte count |
| chunk_valid | output | 1 | Sub-request present |
| chunk_ready | input | 1 | Downstream takes the sub-request |
| chunk_addr | output | 24 | Sub-request start address |
| chunk_len | output | 9 | Sub-request byte count (1 to 256) |
| chunk_off | output | 16 | Offset of the sub-request in the source buffer |
| chunk_done | input | 1 | Downstream finished the accepted sub-request |
| done | output | 1 | One-cycle pulse: whole request finished |

## Verification
The bench builds the block with the package defaults: 24-bit addresses, 16-bit counts and 256-byte pages. These make the largest count, 65535, reachable in one request of 256 sub-requests, and they bring the wrap at the top of the address space within reach from a start near 0xFFFFFF. Each sub-request is checked against a running model of the expected address, length and offset. The bench inserts ready stalls and chunk-done delays, and it presents requests while the block is busy.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

    localparam int WS_ADDR_W     = 24;
    localparam int WS_LEN_W      = 16;
    localparam int WS_PAGE_LOG2  = 8;
    localparam int WS_PAGE_BYTES = 1 << WS_PAGE_LOG2;
    localparam int WS_CHUNK_W    = WS_PAGE_LOG2 + 1;

    typedef logic [WS_ADDR_W-1:0]  addr_t;
    typedef logic [WS_LEN_W-1:0]   count_t;
    typedef logic [WS_CHUNK_W-1:0] clen_t;

    typedef struct packed {
        addr_t  addr;
        clen_t  len;
        count_t off;
    } chunk_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } split_state_e;

    // Bytes to issue now: room left in the current page, capped by what remains.
    function automatic clen_t chunk_len_f(input logic [WS_PAGE_LOG2-1:0] lo,
                                          input count_t rem);
        count_t room;
        room = count_t'(WS_PAGE_BYTES) - count_t'(lo);
        return (rem < room) ? clen_t'(rem) : clen_t'(room);
    endfunction

endpackage

// File: rtl/wsplit_chunk_calc.sv
module wsplit_chunk_calc
    import wsplit_pkg::*;
(
    input  addr_t  cur_addr,
    input  count_t cur_remain,
    input  count_t cur_off,
    output chunk_t chunk
);

    always_comb begin
        chunk.addr = cur_addr;
        chunk.off  = cur_off;
        chunk.len  = chunk_len_f(cur_addr[WS_PAGE_LOG2-1:0], cur_remain);
    end

endmodule

// File: rtl/wsplit_seq.sv
module wsplit_seq
    import wsplit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    output logic   req_ready,
    input  addr_t  req_addr,
    input  count_t req_len,
    input  chunk_t chunk,
    output logic   chunk_valid,
    input  logic   chunk_ready,
    input  logic   chunk_done,
    output logic   done,
    output addr_t  cur_addr,
    output count_t cur_remain,
    output count_t cur_off
);

    split_state_e state;
    logic         done_q;

    assign req_ready   = (state == ST_IDLE);
    assign chunk_valid = (state == ST_ISSUE);
    assign done        = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            done_q     <= 1'b0;
            cur_addr   <= '0;
            cur_remain <= '0;
            cur_off    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            cur_addr   <= req_addr;
                            cur_remain <= req_len;
                            cur_off    <= '0;
                            state      <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (chunk_ready) begin
                        cur_addr   <= cur_addr + addr_t'(chunk.len);
                        cur_off    <= cur_off + count_t'(chunk.len);
                        cur_remain <= cur_remain - count_t'(chunk.len);
                        state      <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (chunk_done) begin
                        if (cur_remain == '0) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_no_cross_R2: assert property (@(posedge clk) disable iff (rst)
        chunk_valid |-> ({1'b0, chunk.addr[WS_PAGE_LOG2-1:0]} + chunk.len) <= clen_t'(WS_PAGE_BYTES));

    assert_later_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && chunk.off != '0) |-> (chunk.addr[WS_PAGE_LOG2-1:0] == '0));

    assert_nonzero_len_R6: assert property (@(posedge clk) disable iff (rst)
        chunk_valid |-> (chunk.len != '0));

    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && !chunk_ready) |=> (chunk_valid && $stable(chunk)));

    assert_wait_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (chunk_valid && chunk_ready) |=> !chunk_valid);

    assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && !chunk_valid));

endmodule

// File: rtl/page_write_splitter.sv
module page_write_splitter
    import wsplit_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [WS_ADDR_W-1:0]  req_addr,
    input  logic [WS_LEN_W-1:0]   req_len,
    output logic                  chunk_valid,
    input  logic                  chunk_ready,
    output logic [WS_ADDR_W-1:0]  chunk_addr,
    output logic [WS_CHUNK_W-1:0] chunk_len,
    output logic [WS_LEN_W-1:0]   chunk_off,
    input  logic                  chunk_done,
    output logic                  done
);

    chunk_t chunk;
    addr_t  cur_addr;
    count_t cur_remain;
    count_t cur_off;

    wsplit_chunk_calc u_calc (
        .cur_addr   (cur_addr),
        .cur_remain (cur_remain),
        .cur_off    (cur_off),
        .chunk      (chunk)
    );

    wsplit_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .chunk       (chunk),
        .chunk_valid (chunk_valid),
        .chunk_ready (chunk_ready),
        .chunk_done  (chunk_done),
        .done        (done),
        .cur_addr    (cur_addr),
        .cur_remain  (cur_remain),
        .cur_off     (cur_off)
    );

    assign chunk_addr = chunk.addr;
    assign chunk_len  = chunk.len;
    assign chunk_off  = chunk.off;

endmodule

// File: tb/tb_page_write_splitter.sv
module tb_page_write_splitter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        chunk_valid;
    logic        chunk_ready = 1'b0;
    logic [23:0] chunk_addr;
    logic [8:0]  chunk_len;
    logic [15:0] chunk_off;
    logic        chunk_done = 1'b0;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    page_write_splitter dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
        .chunk_addr(chunk_addr), .chunk_len(chunk_len), .chunk_off(chunk_off),
        .chunk_done(chunk_done), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drives one request and follows every sub-request against a running model.
    task automatic run_case(input logic [23:0] a, input logic [15:0] n,
                            input int stall, input int dly, input string extra);
        int   ea, er, eo, el, idx;
        logic [23:0] ha;
        logic [8:0]  hl;
        logic [15:0] ho;
        string ta, tl;
        @(negedge clk);
        check(req_ready == 1'b1, "R10", {"idle ready ", extra}, req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_len = n;
        @(negedge clk);
        req_valid = 1'b0;
        if (n == 0) begin
            check(done == 1'b1, "R8", "zero-length done", done, 1);
            check(chunk_valid == 1'b0, "R8", "zero-length no chunk", chunk_valid, 0);
            @(negedge clk);
            check(done == 1'b0 && chunk_valid == 1'b0, "R8", "zero-length single pulse", done, 0);
            return;
        end
        ea = int'(a); er = int'(n); eo = 0; idx = 0;
        while (er != 0) begin
            el = 256 - (ea % 256);
            if (er < el) el = er;
            ta = (idx == 0) ? (((a % 256) == 0) ? "R3" : "R4") : "R5";
            tl = (idx == 0 && (a % 256) != 0) ? "R4" : "R3";
            check(chunk_valid == 1'b1, "R9", {"chunk present ", extra}, chunk_valid, 1);
            check(chunk_addr == 24'(ea), ta, {"chunk addr ", extra}, chunk_addr, ea);
            check(chunk_len == 9'(el), tl, {"chunk len ", extra}, chunk_len, el);
            check(chunk_off == 16'(eo), "R7", {"chunk off ", extra}, chunk_off, eo);
            check((int'(chunk_addr % 256) + int'(chunk_len)) <= 256, "R2", "page crossing",
                  int'(chunk_addr % 256) + int'(chunk_len), 256);
            check(chunk_len != 0, "R6", "nonzero length", chunk_len, el);
            ha = chunk_addr; hl = chunk_len; ho = chunk_off;
            for (int s = 0; s < stall; s++) begin
                req_valid = 1'b1; req_addr = 24'h123456; req_len = 16'd7;
                @(negedge clk);
                check(req_ready == 1'b0, "R10", "busy not ready", req_ready, 0);
                check(chunk_valid && chunk_addr == ha && chunk_len == hl && chunk_off == ho,
                      "R9", "stall hold", {chunk_addr, chunk_len}, {ha, hl});
            end
            req_valid = 1'b0;
            chunk_ready = 1'b1;
            @(negedge clk);
            chunk_ready = 1'b0;
            check(chunk_valid == 1'b0, "R9", "low after accept", chunk_valid, 0);
            ea = (ea + el) % (1 << 24); er = er - el; eo = eo + el; idx++;
            for (int d = 0; d < dly; d++) begin
                @(negedge clk);
                check(chunk_valid == 1'b0 && done == 1'b0, "R9", "wait for chunk_done",
                      chunk_valid, 0);
            end
            chunk_done = 1'b1;
            @(negedge clk);
            chunk_done = 1'b0;
            if (er == 0) check(done == 1'b1, "R10", {"final done ", extra}, done, 1);
            else         check(done == 1'b0, "R10", "no early done", done, 0);
        end
        @(negedge clk);
        check(done == 1'b0 && chunk_valid == 1'b0 && req_ready == 1'b1, "R6",
              {"nothing after last chunk ", extra}, chunk_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(chunk_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R1",
              "reset state", {chunk_valid, done, req_ready}, 3'b001);
        rst = 1'b0;
        run_case(24'h000100, 16'd600, 0, 0, "R3 aligned+rem");
        run_case(24'h000200, 16'd512, 2, 1, "R6 aligned exact");
        run_case(24'h000010, 16'd20,  1, 2, "R4 fits in page");
        run_case(24'h0001F0, 16'd300, 3, 0, "R4 R5 unaligned span");
        run_case(24'h0000FF, 16'd1,   0, 0, "R4 last byte");
        run_case(24'h000000, 16'd0,   0, 0, "R8 zero");
        run_case(24'hFFFFF0, 16'd32,  1, 1, "R11 wrap");
        run_case(24'h004000, 16'hFFFF, 0, 0, "R3 R7 max count");
        run_case(24'h000081, 16'd1000, 0, 3, "R7 unaligned long");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule